// File: doc/BRIEF.md
# Double-Buffered Polyphase Coefficient Store

This block holds the filter coefficients used by a polyphase image scaler. There are six independent tables, one per filter type: luma, chroma and alpha, each in a vertical and a horizontal form. Each table holds phases 0 to 32, which is the lower half of a 64-phase filter plus the centre phase; the scaler folds the upper half by symmetry. Every stored phase holds up to four tap pairs. A pair is an even and an odd coefficient, so a filter can have at most eight taps.

Software loads a table with a register-style protocol. A select write names the filter type and the tap count, and it rewinds an internal pointer to phase 0, pair 0. Each data write then carries an even and an odd coefficient, each with its own enable. The pointer steps through the pairs of a phase first and then moves on to the next phase. The store keeps two complete banks. Loads always go to the bank that is not being read. A mode write picks the bank to read from and sets the chroma-coefficient flag. Both take effect at the next frame-start pulse, so the scaler never sees a table that is only partly loaded.

A read port takes a filter type, a phase and a pair. One cycle later it returns the even and odd coefficients from the active bank.

Top module: `polyphase_coef_ram`

## Requirements
- R1: After reset, cur_bank and chroma_mode are 0 and both read outputs are 0.
- R2: A select write (sel_wr) latches the filter type and the tap count and rewinds the load pointer to phase 0, pair 0. The next data write lands at phase 0, pair 0 of that type.
- R3: Each data write advances the pointer by one pair. After the last pair of a phase the pointer moves to pair 0 of the next phase. The pair count per phase is (taps+1)/2. A tap count of 0 counts as one pair, and a count above 8 is clamped to four pairs.
- R4: Once the pointer has passed the last pair of phase 32, further data writes are dropped until the next select write. They do not wrap around.
- R5: even_en and odd_en gate their own halves. A half whose enable is low keeps its stored value, but the pointer still advances.
- R6: The two low bits of every stored coefficient are zero, whatever was written.
- R7: When the selected tap count is odd (1 to 7), the odd coefficient of the last pair of each phase is stored as zero.
- R8: Data writes go to the bank opposite cur_bank. Entries in the active bank are not changed by loads.
- R9: A mode write takes effect only on a frame_start pulse. If mode_wr and frame_start arrive in the same cycle, the new value takes effect on that edge. cur_bank shows the bank being read.
- R10: The filter type codes are 0 luma vertical, 1 luma horizontal, 2 chroma vertical, 3 chroma horizontal, 4 alpha vertical and 5 alpha horizontal. While chroma_mode is 0, reads of type 2 or 3 return the entries of type 0 or 1 respectively.
- R11: Read data appears one cycle after the address. A phase of 33 or more, or a type of 6 or more, reads as zero.
- R12: A data write in the same cycle as frame_start goes to the bank that was inactive before that edge. A data write in the same cycle as a select write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Select write: latch type and taps, rewind pointer |
| sel_type | input | 3 | Filter type code for the load |
| sel_taps | input | 4 | Tap count for the load |
| data_wr | input | 1 | Coefficient pair write |
| even_coef | input | 14 | Even coefficient |
| even_en | input | 1 | Store the even coefficient |
| odd_coef | input | 14 | Odd coefficient |
| odd_en | input | 1 | Store the odd coefficient |
| mode_wr | input | 1 | Mode write: pending bank and chroma flag |
| mode_bank | input | 1 | Bank to make active |
| mode_chroma | input | 1 | Chroma-coefficient flag |
| frame_start | input | 1 | Frame boundary pulse; applies the pending mode |
| rd_type | input | 3 | Read filter type |
| rd_phase | input | 6 | Read phase |
| rd_pair | input | 2 | Read tap pair |
| rd_even | output | 14 | Even coefficient read |
| rd_odd | output | 14 | Odd coefficient read |
| cur_bank | output | 1 | Active bank |
| chroma_mode | output | 1 | Active chroma-coefficient flag |

## Verification
Two things can coincide in one cycle: a coefficient write and the frame-start pulse that swaps the banks. The bench provokes this by queuing a mode write and then raising frame_start in the same cycle as the last data write of a fresh load. It judges the result by reading that entry back after the swap and expecting the new value, because the write must have gone to the bank that was inactive before the edge. It also drives a select write and a data write together, and a mode write and frame_start together. In each case it checks, through later reads and through cur_bank, which of the two actions took effect.

// File: rtl/poly_coef_pkg.sv
package poly_coef_pkg;
  localparam int NUM_FILT     = 6;
  localparam int FILT_W       = 3;
  localparam int DEF_PHASES   = 33;
  localparam int DEF_MAX_TAPS = 8;
  localparam int DEF_COEF_W   = 14;

  typedef enum logic [FILT_W-1:0] {
    FT_LUMA_V   = 3'd0,
    FT_LUMA_H   = 3'd1,
    FT_CHROMA_V = 3'd2,
    FT_CHROMA_H = 3'd3,
    FT_ALPHA_V  = 3'd4,
    FT_ALPHA_H  = 3'd5
  } filt_e;
endpackage

// File: rtl/coef_wr_ptr.sv
module coef_wr_ptr #(
  parameter int MAX_TAPS = 8,
  parameter int PHASES   = 33
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sel_wr,
  input  logic [2:0]                          sel_type,
  input  logic [$clog2(MAX_TAPS+1)-1:0]       sel_taps,
  input  logic                                data_wr,
  output logic                                wr_go,
  output logic [2:0]                          wr_type,
  output logic [$clog2(PHASES+1)-1:0]         wr_phase,
  output logic [$clog2((MAX_TAPS+1)/2)-1:0]   wr_pair,
  output logic                                wr_zero_odd
);
  import poly_coef_pkg::*;

  localparam int MAX_PAIRS = (MAX_TAPS + 1) / 2;
  localparam int PAIR_W    = $clog2(MAX_PAIRS);
  localparam int CNT_W     = $clog2(MAX_PAIRS + 1);
  localparam int PHASE_W   = $clog2(PHASES + 1);
  localparam int TAP_W     = $clog2(MAX_TAPS + 1);
  localparam logic [PHASE_W-1:0] PH_LIM   = PHASE_W'(PHASES);
  localparam logic [2:0]         TYPE_LIM = 3'(NUM_FILT);

  logic [2:0]         type_q, type_n;
  logic [CNT_W-1:0]   pairs_q, pairs_n;
  logic               odd_q, odd_n;
  logic [PHASE_W-1:0] phase_q, phase_n;
  logic [PAIR_W-1:0]  pair_q, pair_n;
  logic               room, last;

  function automatic logic [CNT_W-1:0] pairs_for(input logic [TAP_W-1:0] t);
    if (t == '0)                 return CNT_W'(1);
    else if (int'(t) > MAX_TAPS) return CNT_W'(MAX_PAIRS);
    else                         return CNT_W'((int'(t) + 1) / 2);
  endfunction

  function automatic logic odd_for(input logic [TAP_W-1:0] t);
    return t[0] && (int'(t) <= MAX_TAPS);
  endfunction

  assign room = phase_q < PH_LIM;
  assign last = (CNT_W'(pair_q) == pairs_q - CNT_W'(1));

  always_comb begin
    type_n  = type_q;
    pairs_n = pairs_q;
    odd_n   = odd_q;
    phase_n = phase_q;
    pair_n  = pair_q;
    if (sel_wr) begin
      type_n  = sel_type;
      pairs_n = pairs_for(sel_taps);
      odd_n   = odd_for(sel_taps);
      phase_n = '0;
      pair_n  = '0;
    end else if (data_wr && room) begin
      if (last) begin
        pair_n  = '0;
        phase_n = phase_q + PHASE_W'(1);
      end else begin
        pair_n  = pair_q + PAIR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q  <= '0;
      pairs_q <= CNT_W'(MAX_PAIRS);
      odd_q   <= 1'b0;
      phase_q <= '0;
      pair_q  <= '0;
    end else begin
      type_q  <= type_n;
      pairs_q <= pairs_n;
      odd_q   <= odd_n;
      phase_q <= phase_n;
      pair_q  <= pair_n;
    end
  end

  assign wr_go       = data_wr && !sel_wr && room && (type_q < TYPE_LIM);
  assign wr_type     = type_q;
  assign wr_phase    = phase_q;
  assign wr_pair     = pair_q;
  assign wr_zero_odd = last && odd_q;

  // R2: a select write rewinds the pointer
  p_sel_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (phase_q == '0 && pair_q == '0));

  // R3: the pair index stays below the pair count of the load
  p_pair_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(pair_q) < pairs_q);

  // R4: a full pointer stays full until the next select write
  p_ptr_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LIM && !sel_wr) |=> (phase_q == PH_LIM));
endmodule

// File: rtl/coef_bank_ctrl.sv
module coef_bank_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_wr,
  input  logic mode_bank,
  input  logic mode_chroma,
  input  logic frame_start,
  output logic act_bank,
  output logic act_chroma
);
  logic pend_bank_q, pend_bank_n;
  logic pend_chr_q, pend_chr_n;
  logic act_bank_n, act_chr_n;

  always_comb begin
    pend_bank_n = mode_wr ? mode_bank   : pend_bank_q;
    pend_chr_n  = mode_wr ? mode_chroma : pend_chr_q;
    act_bank_n  = frame_start ? pend_bank_n : act_bank;
    act_chr_n   = frame_start ? pend_chr_n  : act_chroma;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_bank_q <= 1'b0;
      pend_chr_q  <= 1'b0;
      act_bank    <= 1'b0;
      act_chroma  <= 1'b0;
    end else begin
      pend_bank_q <= pend_bank_n;
      pend_chr_q  <= pend_chr_n;
      act_bank    <= act_bank_n;
      act_chroma  <= act_chr_n;
    end
  end

  // R9: the active bank changes only across a frame-start edge
  p_swap_at_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_bank) |-> $past(frame_start));

  // R9: the chroma flag also changes only at a frame start
  p_chroma_at_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_chroma) |-> $past(frame_start));
endmodule

// File: rtl/coef_store.sv
module coef_store #(
  parameter int COEF_W    = 14,
  parameter int PHASES    = 33,
  parameter int MAX_PAIRS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    wr_en,
  input  logic                          wr_bank,
  input  logic [2:0]                    wr_type,
  input  logic [$clog2(PHASES+1)-1:0]   wr_phase,
  input  logic [$clog2(MAX_PAIRS)-1:0]  wr_pair,
  input  logic [1:0][COEF_W-1:0]        wr_data,
  input  logic                          rd_bank,
  input  logic [2:0]                    rd_type,
  input  logic [5:0]                    rd_phase,
  input  logic [$clog2(MAX_PAIRS)-1:0]  rd_pair,
  output logic [1:0][COEF_W-1:0]        rd_data
);
  import poly_coef_pkg::*;

  localparam int DEPTH   = 2 * NUM_FILT * PHASES * MAX_PAIRS;
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam logic [5:0] RD_PH_LIM = 6'(PHASES);
  localparam logic [2:0] TYPE_LIM  = 3'(NUM_FILT);

  function automatic logic [ADDR_W-1:0] addr_of(input logic b, input logic [2:0] t,
                                               input int ph, input int pr);
    return ADDR_W'(((int'(b) * NUM_FILT + int'(t)) * PHASES + ph) * MAX_PAIRS + pr);
  endfunction

  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              rd_ok;

  assign wr_addr = addr_of(wr_bank, wr_type, int'(wr_phase), int'(wr_pair));
  assign rd_addr = addr_of(rd_bank, rd_type, int'(rd_phase), int'(rd_pair));
  assign rd_ok   = (rd_phase < RD_PH_LIM) && (rd_type < TYPE_LIM);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [COEF_W-1:0] mem [DEPTH];
    logic [COEF_W-1:0] rd_q, rd_n;

    always_ff @(posedge clk) begin
      if (wr_en[g]) mem[wr_addr] <= wr_data[g];
    end

    always_comb rd_n = rd_ok ? mem[rd_addr] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= rd_n;
    end

    assign rd_data[g] = rd_q;
  end

  // R8: a write never targets the bank that is being read
  p_wr_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en) |-> (wr_bank != rd_bank));

  // R11: out-of-range addresses read as zero one cycle later
  p_rd_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase >= RD_PH_LIM || rd_type >= TYPE_LIM) |=> (rd_data == '0));
endmodule

// File: rtl/polyphase_coef_ram.sv
module polyphase_coef_ram #(
  parameter int COEF_W   = poly_coef_pkg::DEF_COEF_W,
  parameter int MAX_TAPS = poly_coef_pkg::DEF_MAX_TAPS,
  parameter int PHASES   = poly_coef_pkg::DEF_PHASES
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sel_wr,
  input  logic [2:0]                          sel_type,
  input  logic [$clog2(MAX_TAPS+1)-1:0]       sel_taps,
  input  logic                                data_wr,
  input  logic [COEF_W-1:0]                   even_coef,
  input  logic                                even_en,
  input  logic [COEF_W-1:0]                   odd_coef,
  input  logic                                odd_en,
  input  logic                                mode_wr,
  input  logic                                mode_bank,
  input  logic                                mode_chroma,
  input  logic                                frame_start,
  input  logic [2:0]                          rd_type,
  input  logic [5:0]                          rd_phase,
  input  logic [$clog2((MAX_TAPS+1)/2)-1:0]   rd_pair,
  output logic [COEF_W-1:0]                   rd_even,
  output logic [COEF_W-1:0]                   rd_odd,
  output logic                                cur_bank,
  output logic                                chroma_mode
);
  import poly_coef_pkg::*;

  localparam int MAX_PAIRS = (MAX_TAPS + 1) / 2;
  localparam int PAIR_W    = $clog2(MAX_PAIRS);
  localparam int PHASE_W   = $clog2(PHASES + 1);

  logic               wr_go, zero_odd;
  logic [2:0]         wr_type;
  logic [PHASE_W-1:0] wr_phase;
  logic [PAIR_W-1:0]  wr_pair;
  logic [1:0]         lane_en;
  logic [1:0][COEF_W-1:0] lane_wd, lane_rd;
  logic [2:0]         eff_type;

  coef_wr_ptr #(.MAX_TAPS(MAX_TAPS), .PHASES(PHASES)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .sel_wr(sel_wr), .sel_type(sel_type), .sel_taps(sel_taps),
    .data_wr(data_wr),
    .wr_go(wr_go), .wr_type(wr_type), .wr_phase(wr_phase),
    .wr_pair(wr_pair), .wr_zero_odd(zero_odd)
  );

  coef_bank_ctrl u_bank (
    .clk(clk), .rst_n(rst_n),
    .mode_wr(mode_wr), .mode_bank(mode_bank), .mode_chroma(mode_chroma),
    .frame_start(frame_start),
    .act_bank(cur_bank), .act_chroma(chroma_mode)
  );

  always_comb begin
    lane_en[0] = wr_go && even_en;
    lane_en[1] = wr_go && odd_en;
    lane_wd[0] = {even_coef[COEF_W-1:2], 2'b00};
    lane_wd[1] = zero_odd ? '0 : {odd_coef[COEF_W-1:2], 2'b00};
    eff_type   = rd_type;
    if (!chroma_mode && (rd_type == FT_CHROMA_V)) eff_type = FT_LUMA_V;
    if (!chroma_mode && (rd_type == FT_CHROMA_H)) eff_type = FT_LUMA_H;
  end

  coef_store #(.COEF_W(COEF_W), .PHASES(PHASES), .MAX_PAIRS(MAX_PAIRS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(lane_en), .wr_bank(~cur_bank), .wr_type(wr_type),
    .wr_phase(wr_phase), .wr_pair(wr_pair), .wr_data(lane_wd),
    .rd_bank(cur_bank), .rd_type(eff_type), .rd_phase(rd_phase),
    .rd_pair(rd_pair), .rd_data(lane_rd)
  );

  assign rd_even = lane_rd[0];
  assign rd_odd  = lane_rd[1];

  // R6: read data never carries the two low bits
  p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_phase) < 6'(PHASES) |-> (rd_even[1:0] == 2'b00 || $isunknown(rd_even)));

  // R12: a data write alongside a select write stores nothing
  p_sel_blocks_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |-> (lane_en == 2'b00));
endmodule

// File: tb/polyphase_coef_ram_test.sv
module polyphase_coef_ram_test;
  localparam int NT = 6, NPH = 33, NPR = 4;
  localparam int DEPTH = 2 * NT * NPH * NPR;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sel_wr, data_wr, even_en, odd_en, mode_wr, mode_bank, mode_chroma, frame_start;
  logic [2:0] sel_type, rd_type;
  logic [3:0] sel_taps;
  logic [13:0] even_coef, odd_coef, rd_even, rd_odd;
  logic [5:0] rd_phase;
  logic [1:0] rd_pair;
  logic cur_bank, chroma_mode;

  polyphase_coef_ram uut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_type(sel_type), .sel_taps(sel_taps),
    .data_wr(data_wr), .even_coef(even_coef), .even_en(even_en), .odd_coef(odd_coef),
    .odd_en(odd_en), .mode_wr(mode_wr), .mode_bank(mode_bank), .mode_chroma(mode_chroma),
    .frame_start(frame_start), .rd_type(rd_type), .rd_phase(rd_phase), .rd_pair(rd_pair),
    .rd_even(rd_even), .rd_odd(rd_odd), .cur_bank(cur_bank), .chroma_mode(chroma_mode)
  );

  int n_chk = 0, n_fail = 0;
  int exp_e [DEPTH];
  int exp_o [DEPTH];
  int m_cur = 0, m_chr = 0, m_pb = 0, m_pc = 0;
  int m_type = 0, m_pairs = 4, m_odd = 0, m_ph = 0, m_pr = 0;
  bit done = 0;

  function automatic int idx(int b, int t, int ph, int pr);
    return ((b * NT + t) * NPH + ph) * NPR + pr;
  endfunction

  function automatic int pairs_of(int taps);
    if (taps == 0) return 1;
    if (taps > 8) return 4;
    return (taps + 1) / 2;
  endfunction

  task automatic check(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic apply_frame();
    m_cur = m_pb;
    m_chr = m_pc;
  endtask

  task automatic tsel(int t, int taps, bit with_data);
    sel_wr = 1; sel_type = 3'(t); sel_taps = 4'(taps);
    data_wr = with_data; even_coef = 14'h1111; odd_coef = 14'h2222; even_en = 1; odd_en = 1;
    m_type = t; m_pairs = pairs_of(taps); m_odd = (taps % 2 == 1) && taps <= 8;
    m_ph = 0; m_pr = 0;
    @(negedge clk);
    sel_wr = 0; data_wr = 0;
  endtask

  task automatic twr(int e, bit ee, int o, bit oe, bit fs);
    int a;
    data_wr = 1; even_coef = 14'(e); odd_coef = 14'(o); even_en = ee; odd_en = oe;
    frame_start = fs;
    if (m_ph < NPH) begin
      if (m_type < NT) begin
        a = idx(1 - m_cur, m_type, m_ph, m_pr);
        if (ee) exp_e[a] = e & 'h3FFC;
        if (oe) exp_o[a] = (m_odd && m_pr == m_pairs - 1) ? 0 : (o & 'h3FFC);
      end
      if (m_pr == m_pairs - 1) begin m_pr = 0; m_ph++; end
      else m_pr++;
    end
    if (fs) apply_frame();
    @(negedge clk);
    data_wr = 0; frame_start = 0;
  endtask

  task automatic tmode(int b, int c, bit fs);
    mode_wr = 1; mode_bank = b[0]; mode_chroma = c[0]; frame_start = fs;
    m_pb = b; m_pc = c;
    if (fs) apply_frame();
    @(negedge clk);
    mode_wr = 0; frame_start = 0;
  endtask

  task automatic tframe();
    frame_start = 1;
    apply_frame();
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic tload(int t, int taps);
    tsel(t, taps, 0);
    for (int ph = 0; ph < NPH; ph++)
      for (int pr = 0; pr < pairs_of(taps); pr++)
        twr($urandom & 'h3FFF, 1, $urandom & 'h3FFF, 1, 0);
  endtask

  task automatic trd(int t, int ph, int pr, string tag);
    int et, a, ee, eo;
    rd_type = 3'(t); rd_phase = 6'(ph); rd_pair = 2'(pr);
    @(negedge clk);
    et = (m_chr == 0 && (t == 2 || t == 3)) ? t - 2 : t;
    if (ph >= NPH || t >= NT) begin ee = 0; eo = 0; end
    else begin
      a = idx(m_cur, et, ph, pr);
      ee = exp_e[a]; eo = exp_o[a];
    end
    if (ee >= 0) check({tag, " even"}, int'(rd_even), ee);
    if (eo >= 0) check({tag, " odd"}, int'(rd_odd), eo);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin exp_e[i] = -1; exp_o[i] = -1; end
    rst_n = 0; sel_wr = 0; sel_type = 0; sel_taps = 0; data_wr = 0; even_coef = 0;
    even_en = 0; odd_coef = 0; odd_en = 0; mode_wr = 0; mode_bank = 0; mode_chroma = 0;
    frame_start = 0; rd_type = 0; rd_phase = 0; rd_pair = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 cur_bank", int'(cur_bank), 0);
    check("R1 chroma_mode", int'(chroma_mode), 0);
    check("R1 rd_even", int'(rd_even), 0);
    check("R1 rd_odd", int'(rd_odd), 0);

    // R2 R3 R7: fill bank 1 with assorted tap counts
    tload(1, 8); tload(0, 5); tload(2, 4); tload(3, 7); tload(4, 1); tload(5, 2);
    // R4: extra writes past phase 32 are dropped
    for (int k = 0; k < 3; k++) twr(14'h3FFF, 1, 14'h3FFF, 1, 0);

    // R9: mode write alone does not swap
    tmode(1, 1, 0);
    repeat (2) @(negedge clk);
    check("R9 no swap before frame", int'(cur_bank), 0);
    tframe();
    check("R9 swap at frame", int'(cur_bank), 1);
    check("R9 chroma at frame", int'(chroma_mode), 1);

    trd(1, 0, 0, "R2 first entry");
    trd(1, 32, 3, "R3 last entry");
    trd(1, 17, 2, "R3 mid entry");
    trd(0, 10, 2, "R7 taps5 last pair");
    check("R7 odd zero taps5", int'(rd_odd), 0);
    trd(4, 5, 0, "R7 taps1");
    check("R7 odd zero taps1", int'(rd_odd), 0);
    trd(3, 9, 3, "R7 taps7");
    check("R7 odd zero taps7", int'(rd_odd), 0);
    trd(5, 0, 0, "R4 no wrap");
    trd(5, 32, 0, "R4 last kept");
    trd(2, 7, 1, "R10 chroma on");
    trd(2, 40, 1, "R11 phase out of range");
    trd(6, 3, 0, "R11 type out of range");
    for (int k = 0; k < 40; k++) begin
      trd($urandom_range(0, 5), $urandom_range(0, 32), $urandom_range(0, 3), "R3 random read");
      check("R6 low bits", int'(rd_even[1:0]) | int'(rd_odd[1:0]), 0);
    end

    // R8: load bank 0 while bank 1 is active
    tload(1, 8); tload(0, 6); tload(2, 8); tload(3, 8);
    trd(1, 4, 1, "R8 active untouched");
    trd(0, 20, 2, "R8 active untouched");

    // R5: partial enables on type 1 in bank 0
    tsel(1, 8, 0);
    twr(14'h0AA4, 1, 14'h0BB8, 0, 0);
    twr(14'h0CC0, 0, 14'h0DD4, 1, 0);
    twr(14'h0EE8, 0, 14'h0FF0, 0, 0);
    twr(14'h1234, 1, 14'h2348, 1, 0);

    // R12: select with data in the same cycle drops the data
    tsel(2, 8, 1);
    twr(14'h1A5C, 1, 14'h2B6D, 1, 0);

    // R12: data write coinciding with frame start goes to the old inactive bank
    tmode(0, 1, 0);
    tsel(3, 8, 0);
    twr(14'h3C78, 1, 14'h2F14, 1, 1);
    check("R12 swap with write", int'(cur_bank), 0);
    trd(3, 0, 0, "R12 write at frame");
    trd(2, 0, 0, "R12 sel drops data");
    trd(1, 0, 0, "R5 even only");
    trd(1, 0, 1, "R5 odd only");
    trd(1, 0, 2, "R5 neither");
    trd(1, 0, 3, "R5 both");

    // R9 R10: mode write with frame in the same cycle, chroma off
    tmode(0, 0, 1);
    check("R9 same-cycle bank", int'(cur_bank), 0);
    check("R9 same-cycle chroma", int'(chroma_mode), 0);
    trd(2, 3, 1, "R10 chroma V maps to luma V");
    trd(3, 30, 3, "R10 chroma H maps to luma H");
    trd(4, 3, 0, "R10 alpha unaffected");
    for (int k = 0; k < 30; k++)
      trd($urandom_range(0, 7), $urandom_range(0, 36), $urandom_range(0, 3), "R11 random read");

    finish_run();
  end
endmodule